// File: doc/BRIEF.md
# Mode-Banked Register File

This block is the 32-bit general register storage for a processor core that runs in several operating modes. Software addresses sixteen logical registers with a 4-bit number. The block maps each logical number to one of 31 physical words. The mapping depends on the current mode, so exception handlers get private stack and link registers, and the fast-interrupt handler also gets private copies of r8 to r12. None of these has to be saved by software. Logical r15 is held as one shared word. Program counter sequencing is handled outside the block.

There are two combinational read ports and one write port, all sharing the current mode. A force-user input makes all general accesses go to the user bank, which privileged block transfers need. The block also keeps one saved-status word for each of the five exception modes. That word has its own write and read path and is selected by the actual mode.

Top module: `bank_regfile`

## Requirements
- R1: Logical r0–r7 and r15 refer to the same physical word in every mode, including unlisted mode codes.
- R2: In fast-interrupt mode, r8–r12 refer to a private bank. Every other mode uses the common r8–r12.
- R3: r13 and r14 have separate copies for fast-interrupt, interrupt, supervisor, abort and undefined modes. User and system mode share one copy.
- R4: Mode codes are user 10000, fast-interrupt 10001, interrupt 10010, supervisor 10011, abort 10111, undefined 11011 and system 11111. Any other 5-bit value behaves exactly like user.
- R5: While `usr_bank_i` is 1, general reads and writes use the user-mode mapping whatever `mode_i` says. Saved-status access still follows `mode_i`.
- R6: Reads are combinational. A write is committed at the rising edge where `wr_en` is 1. In that same cycle, a read of the target register returns the previous contents; the new value is visible after the edge.
- R7: Read ports A and B are independent and may address any two registers, or the same one, in the same cycle.
- R8: Each exception mode owns exactly one saved-status word. `sps_wr_en` writes the word of the current mode, and `sps_rd_data` shows the word of the current mode.
- R9: In user, system or an unlisted mode, `sps_rd_data` is 0 and `sps_wr_en` changes no saved-status word.
- R10: Synchronous active-low reset clears all five saved-status words to 0. It leaves the general registers untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 5 | Current operating mode code |
| usr_bank_i | input | 1 | Force user-bank mapping for general accesses |
| rd_a_idx | input | 4 | Logical register number, read port A |
| rd_a_data | output | 32 | Read data, port A |
| rd_b_idx | input | 4 | Logical register number, read port B |
| rd_b_data | output | 32 | Read data, port B |
| wr_en | input | 1 | General register write enable |
| wr_idx | input | 4 | Logical register number to write |
| wr_data | input | 32 | General register write data |
| sps_wr_en | input | 1 | Saved-status write enable |
| sps_wr_data | input | 32 | Saved-status write data |
| sps_rd_data | output | 32 | Saved-status word of the current mode |

## Verification
The assertions on write visibility and read hold assume that `mode_i`, `usr_bank_i` and the read indices are held steady across the edge they examine. They also assume that a read of a word never written may be unknown, so the hold check is gated on known data. The stimulus changes inputs only just after the falling edge and holds them through the next rising edge. It draws modes from the seven legal codes plus one unlisted code, and it compares a read only against physical words the bench model has already written.

// File: rtl/bank_regfile_pkg.sv
// Package: shared types and mapping helpers for the mode-banked register file.
// Assumes 16 logical registers and the fixed bank layout described in the brief.
package bank_regfile_pkg;

    localparam int NUM_LREG  = 16;
    localparam int LIDX_W    = $clog2(NUM_LREG);
    localparam int NUM_PHYS  = 31;
    localparam int PIDX_W    = $clog2(NUM_PHYS);
    localparam int NUM_SAVED = 5;

    // Register bank selected by a mode; BK_USR also covers system and unlisted codes.
    typedef enum logic [2:0] {
        BK_USR = 3'd0,
        BK_FIQ = 3'd1,
        BK_IRQ = 3'd2,
        BK_SVC = 3'd3,
        BK_ABT = 3'd4,
        BK_UND = 3'd5
    } bank_e;

    // Turn a 5-bit mode code into a bank.
    function automatic bank_e decode_mode(input logic [4:0] m);
        case (m)
            5'b10001: return BK_FIQ;
            5'b10010: return BK_IRQ;
            5'b10011: return BK_SVC;
            5'b10111: return BK_ABT;
            5'b11011: return BK_UND;
            default:  return BK_USR;
        endcase
    endfunction

    // Physical layout: 0..15 common r0..r15, 16..22 fast-interrupt r8..r14,
    // then r13/r14 pairs at 23 (irq), 25 (svc), 27 (abt), 29 (und).
    function automatic logic [PIDX_W-1:0] to_phys(input bank_e b, input logic [LIDX_W-1:0] l);
        logic [PIDX_W-1:0] lw;
        lw = PIDX_W'(l);
        if (l < 4'd8 || l == 4'd15) return lw;
        if (b == BK_FIQ)            return lw + 5'd8;
        if (l < 4'd13)              return lw;
        case (b)
            BK_IRQ:  return lw + 5'd10;
            BK_SVC:  return lw + 5'd12;
            BK_ABT:  return lw + 5'd14;
            BK_UND:  return lw + 5'd16;
            default: return lw;
        endcase
    endfunction

endpackage

// File: rtl/bank_map.sv
// Module: bank_map
// Converts the mode and force-user input into a bank, and maps every logical
// index of the block's ports to a physical word index.
// Assumes purely combinational use; holds no state.
module bank_map
    import bank_regfile_pkg::*;
#(
    parameter int NPORT = 3
) (
    input  logic [4:0]                    mode_i,
    input  logic                          usr_bank_i,
    input  logic [NPORT-1:0][LIDX_W-1:0]  lidx_i,
    output logic [NPORT-1:0][PIDX_W-1:0]  pidx_o,
    output bank_e                         mode_bank_o
);

    bank_e gpr_bank;

    // Pick the bank used for general accesses (the forced user bank, or the mode's own).
    always_comb begin
        mode_bank_o = decode_mode(mode_i);
        gpr_bank    = usr_bank_i ? BK_USR : mode_bank_o;
    end

    for (genvar g = 0; g < NPORT; g++) begin : g_port
        // Map one logical index to its physical word.
        always_comb pidx_o[g] = to_phys(gpr_bank, lidx_i[g]);
    end

endmodule

// File: rtl/gpr_array.sv
// Module: gpr_array
// Physical general register storage with NRD combinational read ports and
// one synchronous write port. Has no reset, by design; contents are unknown until written.
module gpr_array #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 31,
    parameter int NRD    = 2,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic                         clk,
    input  logic                         we,
    input  logic [AW-1:0]                waddr,
    input  logic [DATA_W-1:0]            wdata,
    input  logic [NRD-1:0][AW-1:0]       raddr,
    output logic [NRD-1:0][DATA_W-1:0]   rdata
);

    logic [DATA_W-1:0] mem [DEPTH];

    // Commit a write at the clock edge.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        // Combinational read; a same-cycle write is not bypassed.
        always_comb rdata[g] = mem[raddr[g]];
    end

endmodule

// File: rtl/saved_bank.sv
// Module: saved_bank
// One saved-status word per exception bank, cleared by synchronous active-low reset.
// Assumes bank values 1..NUM_SAVED name the exception banks; 0 has no word.
module saved_bank
    import bank_regfile_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  bank_e              bank_i,
    input  logic               we,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata
);

    logic [NUM_SAVED-1:0]             wen;
    logic [NUM_SAVED-1:0][DATA_W-1:0] store;

    for (genvar i = 0; i < NUM_SAVED; i++) begin : g_word
        // Decode the write enable of this word.
        always_comb wen[i] = we && (bank_i == bank_e'(i + 1));

        // Hold one saved-status word.
        always_ff @(posedge clk) begin
            if (!rst_n)      store[i] <= '0;
            else if (wen[i]) store[i] <= wdata;
        end
    end

    // Select the current bank's word; no word exists for the user bank.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_SAVED; i++) begin
            if (bank_i == bank_e'(i + 1)) rdata = store[i];
        end
    end

    // R8: at most one saved-status word is written per cycle
    p_one_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wen));

    // R9: a write in a bank without a saved word leaves every word unchanged
    p_user_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (we && bank_i == BK_USR) |=> $stable(store));

    // R10: reset clears every saved word
    p_reset_clear_r10: assert property (@(posedge clk)
        !rst_n |=> (store == '0));

endmodule

// File: rtl/bank_regfile.sv
// Module: bank_regfile (top)
// Mode-banked register file: two read ports, one write port, and per-mode
// saved-status words. Assumes the mode and force-user inputs are stable
// around each clock edge at which they matter.
module bank_regfile
    import bank_regfile_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4:0]        mode_i,
    input  logic              usr_bank_i,
    input  logic [3:0]        rd_a_idx,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [3:0]        rd_b_idx,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              wr_en,
    input  logic [3:0]        wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              sps_wr_en,
    input  logic [DATA_W-1:0] sps_wr_data,
    output logic [DATA_W-1:0] sps_rd_data
);

    localparam int NPORT = 3;
    localparam int NRD   = 2;

    logic [NPORT-1:0][LIDX_W-1:0] lidx;
    logic [NPORT-1:0][PIDX_W-1:0] pidx;
    logic [NRD-1:0][PIDX_W-1:0]   raddr;
    logic [NRD-1:0][DATA_W-1:0]   rdata;
    bank_e                        mode_bank;

    // Gather the logical indices: slot 0 write, 1 read A, 2 read B.
    always_comb begin
        lidx[0] = wr_idx;
        lidx[1] = rd_a_idx;
        lidx[2] = rd_b_idx;
        raddr[0] = pidx[1];
        raddr[1] = pidx[2];
        rd_a_data = rdata[0];
        rd_b_data = rdata[1];
    end

    bank_map #(.NPORT(NPORT)) u_map (
        .mode_i      (mode_i),
        .usr_bank_i  (usr_bank_i),
        .lidx_i      (lidx),
        .pidx_o      (pidx),
        .mode_bank_o (mode_bank)
    );

    gpr_array #(.DATA_W(DATA_W), .DEPTH(NUM_PHYS), .NRD(NRD)) u_gpr (
        .clk   (clk),
        .we    (wr_en),
        .waddr (pidx[0]),
        .wdata (wr_data),
        .raddr (raddr),
        .rdata (rdata)
    );

    saved_bank #(.DATA_W(DATA_W)) u_sps (
        .clk    (clk),
        .rst_n  (rst_n),
        .bank_i (mode_bank),
        .we     (sps_wr_en),
        .wdata  (sps_wr_data),
        .rdata  (sps_rd_data)
    );

    // R1: shared registers map to the index of the same number
    p_shared_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_idx < 4'd8 || rd_a_idx == 4'd15) |-> (pidx[1] == PIDX_W'(rd_a_idx)));

    // R2: fast-interrupt r8..r14 never land in the common words
    p_fiq_private_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 5'b10001 && !usr_bank_i && rd_a_idx >= 4'd8 && rd_a_idx <= 4'd14)
            |-> (pidx[1] >= 5'd16));

    // R5: the forced user bank never selects a banked word
    p_force_user_r5: assert property (@(posedge clk) disable iff (!rst_n)
        usr_bank_i |-> (pidx[0] < 5'd16 && pidx[1] < 5'd16 && pidx[2] < 5'd16));

    // R6: a written value is visible on port A after the edge
    p_write_visible_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((rd_a_idx == $past(wr_idx) && $stable(mode_i) && $stable(usr_bank_i))
                   -> (rd_a_data == $past(wr_data))));

    // R6: with no write, a steady read address returns steady data
    p_read_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !$isunknown(rd_a_data)) |=>
            ((rd_a_idx == $past(rd_a_idx) && $stable(mode_i) && $stable(usr_bank_i))
             -> (rd_a_data == $past(rd_a_data))));

endmodule

// File: tb/bank_regfile_test.sv
`timescale 1ns/1ps
module bank_regfile_test;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [4:0]   mode_i;
    logic         usr_bank_i;
    logic [3:0]   rd_a_idx, rd_b_idx, wr_idx;
    logic [W-1:0] rd_a_data, rd_b_data, wr_data, sps_wr_data, sps_rd_data;
    logic         wr_en, sps_wr_en;

    int errors = 0;
    int checks = 0;

    logic [W-1:0] ref_gpr [31];
    bit           ref_ok  [31];
    logic [W-1:0] ref_sps [6];

    localparam logic [4:0] M_USR = 5'b10000, M_FIQ = 5'b10001, M_IRQ = 5'b10010,
                           M_SVC = 5'b10011, M_ABT = 5'b10111, M_UND = 5'b11011,
                           M_SYS = 5'b11111, M_BAD = 5'b00101;

    always #2.5 clk = ~clk;

    bank_regfile uut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .usr_bank_i(usr_bank_i),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data), .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .sps_wr_en(sps_wr_en), .sps_wr_data(sps_wr_data), .sps_rd_data(sps_rd_data)
    );

    // Bank number from the mode codes of R4 (0 = user/system/unlisted).
    function automatic int bank_of(input logic [4:0] m);
        case (m)
            M_FIQ:   return 1;
            M_IRQ:   return 2;
            M_SVC:   return 3;
            M_ABT:   return 4;
            M_UND:   return 5;
            default: return 0;
        endcase
    endfunction

    // Model slot for a logical register, from R1, R2, R3 and R5.
    function automatic int slot_of(input logic [4:0] m, input bit f, input int l);
        int b;
        b = f ? 0 : bank_of(m);
        if (l < 8 || l == 15) return l;
        if (b == 1) return 16 + (l - 8);
        if (l < 13 || b == 0) return l;
        return 23 + 2 * (b - 2) + (l - 13);
    endfunction

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic gwrite(input logic [4:0] m, input bit f, input int l, input logic [W-1:0] d);
        @(negedge clk);
        mode_i = m; usr_bank_i = f; wr_idx = 4'(l); wr_data = d; wr_en = 1'b1;
        @(posedge clk);
        #1 wr_en = 1'b0;
        ref_gpr[slot_of(m, f, l)] = d;
        ref_ok[slot_of(m, f, l)]  = 1'b1;
    endtask

    task automatic gread(input string req, input logic [4:0] m, input bit f, input int l,
                         input logic [W-1:0] exp);
        @(negedge clk);
        mode_i = m; usr_bank_i = f; rd_a_idx = 4'(l); rd_b_idx = 4'(l); wr_en = 1'b0;
        #1;
        chk(req, rd_a_data, exp);
    endtask

    task automatic swrite(input logic [4:0] m, input logic [W-1:0] d);
        @(negedge clk);
        mode_i = m; usr_bank_i = 1'b0; sps_wr_data = d; sps_wr_en = 1'b1;
        @(posedge clk);
        #1 sps_wr_en = 1'b0;
        if (bank_of(m) != 0) ref_sps[bank_of(m)] = d;
    endtask

    task automatic sread(input string req, input logic [4:0] m, input bit f, input logic [W-1:0] exp);
        @(negedge clk);
        mode_i = m; usr_bank_i = f; sps_wr_en = 1'b0;
        #1;
        chk(req, sps_rd_data, exp);
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [4:0] modes [8];
        modes = '{M_USR, M_FIQ, M_IRQ, M_SVC, M_ABT, M_UND, M_SYS, M_BAD};
        void'($urandom(32'd1234));
        for (int i = 0; i < 31; i++) ref_ok[i] = 1'b0;
        for (int i = 0; i < 6; i++) ref_sps[i] = '0;
        rst_n = 1'b0; mode_i = M_USR; usr_bank_i = 1'b0; rd_a_idx = '0; rd_b_idx = '0;
        wr_en = 1'b0; wr_idx = '0; wr_data = '0; sps_wr_en = 1'b0; sps_wr_data = '0;
        // R10: a saved-status write during reset is dropped, reset clears all words
        @(negedge clk); mode_i = M_SVC; sps_wr_en = 1'b1; sps_wr_data = 32'hDEAD_0001;
        repeat (3) @(negedge clk);
        sps_wr_en = 1'b0; rst_n = 1'b1;
        for (int k = 1; k < 6; k++) sread("R10 reset", modes[k], 1'b0, '0);

        // R1: shared low registers and r15 seen from every mode
        gwrite(M_USR, 0, 3, 32'h0303_0303);
        gwrite(M_IRQ, 0, 15, 32'h1515_1515);
        for (int k = 0; k < 8; k++) begin
            gread("R1 r3 shared", modes[k], 0, 3, 32'h0303_0303);
            gread("R1 r15 shared", modes[k], 0, 15, 32'h1515_1515);
        end

        // R2: fast-interrupt r9 private, others common
        gwrite(M_USR, 0, 9, 32'hAAAA_0009);
        gwrite(M_FIQ, 0, 9, 32'hBBBB_0009);
        gread("R2 irq sees common r9", M_IRQ, 0, 9, 32'hAAAA_0009);
        gread("R2 fiq sees private r9", M_FIQ, 0, 9, 32'hBBBB_0009);

        // R3: r13 copies per bank; system shares with user
        for (int k = 0; k < 6; k++) gwrite(modes[k], 0, 13, 32'h1300_0000 + 32'(k));
        for (int k = 0; k < 6; k++) gread("R3 r13 bank", modes[k], 0, 13, 32'h1300_0000 + 32'(k));
        gread("R3 system uses user r13", M_SYS, 0, 13, 32'h1300_0000);
        gwrite(M_SYS, 0, 14, 32'h1400_00FF);
        gread("R3 user sees system r14", M_USR, 0, 14, 32'h1400_00FF);

        // R4: unlisted code behaves as user
        gread("R4 unlisted r13", M_BAD, 0, 13, 32'h1300_0000);
        gread("R4 unlisted r9", M_BAD, 0, 9, 32'hAAAA_0009);

        // R5: force user bank from fast-interrupt mode
        gwrite(M_FIQ, 1, 10, 32'hCCCC_0010);
        gread("R5 user sees forced write", M_USR, 0, 10, 32'hCCCC_0010);
        gwrite(M_FIQ, 0, 10, 32'hDDDD_0010);
        gread("R5 forced read goes to user", M_FIQ, 1, 10, 32'hCCCC_0010);
        gread("R5 private r10 intact", M_FIQ, 0, 10, 32'hDDDD_0010);

        // R6: same-cycle read returns old value, new after edge
        @(negedge clk);
        mode_i = M_USR; usr_bank_i = 0; rd_a_idx = 4'd3; wr_idx = 4'd3;
        wr_data = 32'h0606_0606; wr_en = 1'b1;
        #1 chk("R6 old value same cycle", rd_a_data, 32'h0303_0303);
        @(posedge clk);
        #1 chk("R6 new value after edge", rd_a_data, 32'h0606_0606);
        wr_en = 1'b0;
        ref_gpr[3] = 32'h0606_0606;

        // R7: two ports at once
        @(negedge clk);
        mode_i = M_FIQ; usr_bank_i = 0; rd_a_idx = 4'd9; rd_b_idx = 4'd15;
        #1;
        chk("R7 port A", rd_a_data, 32'hBBBB_0009);
        chk("R7 port B", rd_b_data, 32'h1515_1515);

        // R8: saved words per exception mode
        for (int k = 1; k < 6; k++) swrite(modes[k], 32'h5000_0000 + 32'(k));
        for (int k = 1; k < 6; k++) sread("R8 saved word", modes[k], 0, 32'h5000_0000 + 32'(k));
        sread("R5 saved word ignores force", M_ABT, 1, 32'h5000_0004);

        // R9: no saved word in user/system/unlisted
        swrite(M_USR, 32'hEEEE_EEEE);
        swrite(M_SYS, 32'hEEEE_EEEE);
        swrite(M_BAD, 32'hEEEE_EEEE);
        sread("R9 user read zero", M_USR, 0, '0);
        sread("R9 system read zero", M_SYS, 0, '0);
        for (int k = 1; k < 6; k++) sread("R9 words untouched", modes[k], 0, 32'h5000_0000 + 32'(k));

        // Random mix checked against the model
        for (int n = 0; n < 3000; n++) begin
            int op;
            logic [4:0] m;
            bit f;
            int la, lb;
            op = int'($urandom_range(0, 9));
            m  = modes[$urandom_range(0, 7)];
            f  = ($urandom_range(0, 7) == 0);
            la = int'($urandom_range(0, 15));
            lb = int'($urandom_range(0, 15));
            if (op < 4) begin
                gwrite(m, f, la, $urandom());
            end else if (op < 8) begin
                @(negedge clk);
                mode_i = m; usr_bank_i = f; rd_a_idx = 4'(la); rd_b_idx = 4'(lb); wr_en = 1'b0;
                #1;
                if (ref_ok[slot_of(m, f, la)]) chk("R1/R2/R3 random port A", rd_a_data, ref_gpr[slot_of(m, f, la)]);
                if (ref_ok[slot_of(m, f, lb)]) chk("R7 random port B", rd_b_data, ref_gpr[slot_of(m, f, lb)]);
            end else if (op == 8) begin
                swrite(m, $urandom());
            end else begin
                sread("R8/R9 random saved", m, f, ref_sps[bank_of(m)]);
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule